// File: doc/BRIEF.md
# Completion Stream Rule Monitor

This block sits passively beside a Dword-organised valid/ready completion stream that runs from a user application toward a PCIe endpoint. It drives nothing on that stream. It samples the data, keep, last, user, valid and ready pins on every clock edge and checks that the sender obeys the packet rules.

The stream rules are as follows. A beat moves only in a cycle where valid and ready are both high. When the receiver holds ready low, the sender must keep valid high and must hold the beat steady until ready returns. Inside a packet, valid may not drop until the beat marked last has moved. Each beat carries one keep bit per 32-bit Dword.

Each kind of violation has its own sticky flag and its own one-cycle pulse, so an integrator can trap the first failure or count them. The block also counts completed packets. The configured width (64, 128 or 256 bits) decides how many keep lanes and data bits are significant. Lanes and bits above that width are ignored.

Top module: `cmpl_stream_chk`

## Requirements
- R1: `pkt_count` (16 bits, wrapping) rises by one at each clock edge where valid, ready and last are all high. It changes at no other edge, and `clr` does not affect it.
- R2: Error index 0 (stability) is raised when the previous cycle had valid high and ready low, and the current cycle has valid low or any change in the significant data bits, the significant keep lanes, last, or user.
- R3: Error index 1 (gap) is raised when valid is low in a cycle that lies after an accepted non-last beat and before the accepted last beat of the same packet.
- R4: Error index 2 (partial non-final) is raised when an accepted beat with last low has any significant keep lane cleared.
- R5: Error index 3 (keep hole) is raised when an accepted last beat has a significant keep pattern that is not of the form 0…01…1, counted from lane 0.
- R6: Error index 4 (empty beat) is raised when an accepted beat has all significant keep lanes cleared.
- R7: Only keep lanes below DATA_W/32 and data bits below DATA_W count. At DATA_W=128, keep[7:4] and data[255:128] have no effect on any flag.
- R8: A violation sampled at edge k sets its bit in `err_sticky` and `err_pulse` at edge k. The pulse lasts exactly one cycle. A sticky bit stays set until an edge where `clr` is high and the same error is not detected again; a new detection takes priority over `clr`.
- R9: While `rst_n` is low at a clock edge, all flags, pulses and the counter are cleared, and the monitor returns to the outside-a-packet state.
- R10: An accepted beat with last high on the first beat of a packet completes that packet on its own. A valid-low cycle after it raises no gap error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sticky error flags |
| tdata | input | 256 | Observed data bus; the low DATA_W bits are significant |
| tkeep | input | 8 | Observed Dword enables; the low DATA_W/32 lanes are significant |
| tlast | input | 1 | Observed end-of-packet marker |
| tuser | input | 33 | Observed sideband bits, compared only while a beat is stalled |
| tvalid | input | 1 | Observed sender valid |
| tready | input | 1 | Observed receiver ready |
| err_sticky | output | 5 | Sticky flags: [0] stability, [1] gap, [2] partial non-final, [3] keep hole, [4] empty beat |
| err_pulse | output | 5 | One-cycle pulse per detection, same bit order |
| pkt_count | output | 16 | Count of accepted last beats |

## Verification
The hardest case to reach is a valid drop during a stalled beat inside a packet. That single cycle must raise both the stability and gap errors. Reaching it requires an accepted non-last beat, then a stalled beat, then valid falling while ready is still low. The stimulus table builds that sequence on purpose. It also places stalls that end cleanly, or that change only ignored upper lanes, right next to the violating cases, so the bench can tell masked bits from compared ones.

// File: rtl/cmpl_chk_pkg.sv
`timescale 1ns/1ps
package cmpl_chk_pkg;
  localparam int BUS_W   = 256;
  localparam int KEEP_W  = 8;
  localparam int USER_W  = 33;
  localparam int CNT_W   = 16;
  localparam int NUM_ERR = 5;

  localparam int E_STAB  = 0;
  localparam int E_GAP   = 1;
  localparam int E_PART  = 2;
  localparam int E_HOLE  = 3;
  localparam int E_EMPTY = 4;

  function automatic logic [KEEP_W-1:0] lanes_of(input int dw);
    lanes_of = KEEP_W'((1 << (dw / 32)) - 1);
  endfunction
endpackage

// File: rtl/ccs_hold_mon.sv
`timescale 1ns/1ps
module ccs_hold_mon
  import cmpl_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tvalid,
  input  logic              tready,
  input  logic [BUS_W-1:0]  data_m,
  input  logic [KEEP_W-1:0] keep_m,
  input  logic              tlast,
  input  logic [USER_W-1:0] tuser,
  output logic              viol
);
  logic              stalled_q;
  logic [BUS_W-1:0]  data_q;
  logic [KEEP_W-1:0] keep_q;
  logic              last_q;
  logic [USER_W-1:0] user_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stalled_q <= 1'b0;
      data_q    <= '0;
      keep_q    <= '0;
      last_q    <= 1'b0;
      user_q    <= '0;
    end else begin
      stalled_q <= tvalid && !tready;
      data_q    <= data_m;
      keep_q    <= keep_m;
      last_q    <= tlast;
      user_q    <= tuser;
    end
  end

  always_comb begin
    viol = stalled_q && (!tvalid || (data_m != data_q) || (keep_m != keep_q) ||
                         (tlast != last_q) || (tuser != user_q));
  end
endmodule

// File: rtl/ccs_keep_chk.sv
`timescale 1ns/1ps
module ccs_keep_chk
  import cmpl_chk_pkg::*;
#(
  parameter logic [KEEP_W-1:0] LANE_MASK = 8'hFF
) (
  input  logic              beat,
  input  logic              tlast,
  input  logic [KEEP_W-1:0] keep_m,
  output logic              partial,
  output logic              hole,
  output logic              empty
);
  logic [KEEP_W-1:0] plus_one;

  always_comb begin
    plus_one = keep_m + KEEP_W'(1);
    empty    = beat && (keep_m == '0);
    partial  = beat && !tlast && (keep_m != LANE_MASK);
    hole     = beat && tlast && ((keep_m & plus_one) != '0);
  end
endmodule

// File: rtl/ccs_pkt_track.sv
`timescale 1ns/1ps
module ccs_pkt_track
  import cmpl_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tvalid,
  input  logic             beat,
  input  logic             tlast,
  output logic             in_pkt,
  output logic             gap,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      count  <= '0;
    end else if (beat) begin
      in_pkt <= !tlast;
      if (tlast) count <= count + CNT_W'(1);
    end
  end

  always_comb gap = in_pkt && !tvalid;
endmodule

// File: rtl/ccs_err_regs.sv
`timescale 1ns/1ps
module ccs_err_regs
  import cmpl_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_ERR-1:0] set,
  output logic [NUM_ERR-1:0] sticky,
  output logic [NUM_ERR-1:0] pulse
);
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sticky[i] <= 1'b0;
        pulse[i]  <= 1'b0;
      end else begin
        pulse[i] <= set[i];
        if (set[i])   sticky[i] <= 1'b1;
        else if (clr) sticky[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmpl_stream_chk.sv
`timescale 1ns/1ps
module cmpl_stream_chk
  import cmpl_chk_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [255:0]       tdata,
  input  logic [7:0]         tkeep,
  input  logic               tlast,
  input  logic [32:0]        tuser,
  input  logic               tvalid,
  input  logic               tready,
  output logic [4:0]         err_sticky,
  output logic [4:0]         err_pulse,
  output logic [15:0]        pkt_count
);
  localparam logic [KEEP_W-1:0] LANE_MASK = lanes_of(DATA_W);
  localparam logic [BUS_W-1:0]  DATA_MASK = {BUS_W{1'b1}} >> (BUS_W - DATA_W);

  logic [BUS_W-1:0]   data_m;
  logic [KEEP_W-1:0]  keep_m;
  logic               beat;
  logic               in_pkt;
  logic [NUM_ERR-1:0] det;

  always_comb begin
    data_m = tdata & DATA_MASK;
    keep_m = tkeep & LANE_MASK;
    beat   = tvalid && tready;
  end

  ccs_hold_mon u_hold (
    .clk(clk), .rst_n(rst_n), .tvalid(tvalid), .tready(tready),
    .data_m(data_m), .keep_m(keep_m), .tlast(tlast), .tuser(tuser),
    .viol(det[E_STAB])
  );

  ccs_keep_chk #(.LANE_MASK(LANE_MASK)) u_keep (
    .beat(beat), .tlast(tlast), .keep_m(keep_m),
    .partial(det[E_PART]), .hole(det[E_HOLE]), .empty(det[E_EMPTY])
  );

  ccs_pkt_track u_track (
    .clk(clk), .rst_n(rst_n), .tvalid(tvalid), .beat(beat), .tlast(tlast),
    .in_pkt(in_pkt), .gap(det[E_GAP]), .count(pkt_count)
  );

  ccs_err_regs u_err (
    .clk(clk), .rst_n(rst_n), .clr(clr), .set(det),
    .sticky(err_sticky), .pulse(err_pulse)
  );
endmodule

// File: rtl/cmpl_stream_chk_sva.sv
`timescale 1ns/1ps
module cmpl_stream_chk_sva
  import cmpl_chk_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic [7:0]  tkeep,
  input logic        tlast,
  input logic        tvalid,
  input logic        tready,
  input logic        in_pkt,
  input logic [4:0]  err_sticky,
  input logic [4:0]  err_pulse,
  input logic [15:0] pkt_count
);
  localparam logic [7:0] LM = lanes_of(DATA_W);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && tlast) |=> (pkt_count == $past(pkt_count) + 16'd1));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(tvalid && tready && tlast) |=> $stable(pkt_count));

  assert_stab_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tvalid && !tready) && !tvalid) |=> err_pulse[0]);

  assert_gap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && !tvalid) |=> err_pulse[1]);

  assert_partial_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && !tlast && ((tkeep & LM) != LM)) |=> err_pulse[2]);

  assert_empty_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && ((tkeep & LM) == 8'h00)) |=> err_pulse[4]);

  assert_sticky_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));
endmodule

bind cmpl_stream_chk cmpl_stream_chk_sva #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .tkeep(tkeep), .tlast(tlast),
  .tvalid(tvalid), .tready(tready), .in_pkt(in_pkt),
  .err_sticky(err_sticky), .err_pulse(err_pulse), .pkt_count(pkt_count)
);

// File: tb/cmpl_stream_chk_tb.sv
`timescale 1ns/1ps
module cmpl_stream_chk_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic [255:0] tdata = '0;
  logic [7:0]   tkeep = '0;
  logic         tlast = 1'b0;
  logic [32:0]  tuser = '0;
  logic         tvalid = 1'b0;
  logic         tready = 1'b0;
  logic [4:0]   err_sticky;
  logic [4:0]   err_pulse;
  logic [15:0]  pkt_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmpl_stream_chk #(.DATA_W(128)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tdata(tdata), .tkeep(tkeep),
    .tlast(tlast), .tuser(tuser), .tvalid(tvalid), .tready(tready),
    .err_sticky(err_sticky), .err_pulse(err_pulse), .pkt_count(pkt_count)
  );

  typedef struct packed {
    logic       v;
    logic       r;
    logic       l;
    logic       hi;
    logic [7:0] keep;
    logic [7:0] tag;
    logic [4:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0,8'h0F,8'h01,5'h00}, // R10 one-beat packet
    '{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,5'h00}, // R10 idle, no gap
    '{1'b1,1'b1,1'b0,1'b0,8'hFF,8'h02,5'h00}, // R7 upper lanes ignored
    '{1'b1,1'b1,1'b1,1'b0,8'h07,8'h03,5'h00}, // R5 contiguous end
    '{1'b1,1'b0,1'b0,1'b0,8'h0F,8'h04,5'h00}, // R2 stall
    '{1'b1,1'b0,1'b0,1'b0,8'h0F,8'h04,5'h00}, // R2 held
    '{1'b1,1'b1,1'b0,1'b0,8'h0F,8'h04,5'h00}, // accepted non-last
    '{1'b0,1'b1,1'b0,1'b0,8'h0F,8'h04,5'h02}, // R3 bubble
    '{1'b1,1'b1,1'b1,1'b0,8'h05,8'h05,5'h08}, // R5 hole
    '{1'b1,1'b1,1'b0,1'b0,8'h07,8'h06,5'h04}, // R4 partial
    '{1'b1,1'b1,1'b1,1'b0,8'h00,8'h07,5'h10}, // R6 empty last
    '{1'b1,1'b0,1'b0,1'b0,8'h0F,8'h08,5'h00}, // stall
    '{1'b1,1'b0,1'b0,1'b0,8'h0F,8'h09,5'h01}, // R2 data changed
    '{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,5'h01}, // R2 valid dropped
    '{1'b1,1'b1,1'b0,1'b0,8'h0F,8'h0A,5'h00},
    '{1'b1,1'b0,1'b1,1'b0,8'h03,8'h0B,5'h00},
    '{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,5'h03}, // R2 and R3 together
    '{1'b1,1'b1,1'b1,1'b0,8'h0F,8'h0C,5'h00},
    '{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,5'h00},
    '{1'b1,1'b1,1'b1,1'b0,8'hF3,8'h0D,5'h00}, // R7 masked keep contiguous
    '{1'b1,1'b0,1'b1,1'b0,8'h0F,8'h0E,5'h00},
    '{1'b1,1'b1,1'b1,1'b1,8'h0F,8'h0E,5'h00}  // R7 upper data change ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] e);
    if (e[0] && e[1]) return "R2/R3 stall drop in packet";
    if (e[0]) return "R2 stability";
    if (e[1]) return "R3 gap";
    if (e[2]) return "R4 partial";
    if (e[3]) return "R5 hole";
    if (e[4]) return "R6 empty";
    return "R7/R10 clean beat";
  endfunction

  task automatic drive(input vec_t x);
    tvalid = x.v;
    tready = x.r;
    tlast  = x.l;
    tkeep  = x.keep;
    tdata  = {{128{x.hi}}, {16{x.tag}}};
    tuser  = {1'b0, {4{x.tag}}};
  endtask

  task automatic idle();
    drive('{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,5'h00});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4:0] acc;
    acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset sticky", 32'(err_sticky), 32'h0);
    check("R9 reset pulse", 32'(err_pulse), 32'h0);
    check("R9 reset count", 32'(pkt_count), 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      acc |= VEC[i].exp;
      check(req_of(VEC[i].exp), 32'(err_pulse), 32'(VEC[i].exp));
      check("R8 sticky accumulate", 32'(err_sticky), 32'(acc));
    end
    idle();
    @(negedge clk);
    check("R8 pulse lasts one cycle", 32'(err_pulse), 32'h0);
    check("R1 packet count", 32'(pkt_count), 32'd7);

    // R8 clear
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R8 clear sticky", 32'(err_sticky), 32'h0);
    check("R1 count unaffected by clr", 32'(pkt_count), 32'd7);

    // R8 detection wins over clear
    drive('{1'b1,1'b0,1'b0,1'b0,8'h0F,8'h21,5'h00});
    @(negedge clk);
    idle();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R8 set beats clr", 32'(err_sticky), 32'h01);
    check("R2 stall drop pulse", 32'(err_pulse), 32'h01);

    // R9 reset mid-packet leaves no packet state
    drive('{1'b1,1'b1,1'b0,1'b0,8'h0F,8'h31,5'h00});
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 no gap after reset", 32'(err_pulse), 32'h0);
    check("R9 sticky cleared", 32'(err_sticky), 32'h0);
    check("R9 count cleared", 32'(pkt_count), 32'h0);

    // R4 zero keep non-final raises partial and empty
    drive('{1'b1,1'b1,1'b0,1'b0,8'hF0,8'h41,5'h00});
    @(negedge clk);
    check("R4/R6 masked zero non-final", 32'(err_pulse), 32'h14);
    drive('{1'b1,1'b1,1'b1,1'b0,8'h0F,8'h42,5'h00});
    @(negedge clk);
    idle();
    check("R1 count after close", 32'(pkt_count), 32'd1);

    finish_run();
  end
endmodule